// File: doc/BRIEF.md
# CAN Message Timestamp Timer

This block is the time base that a CAN controller uses to mark when messages complete. A counter, 16 bits wide by default, advances once per prescaled tick while the controller is enabled. Each tick lasts eight system clocks times one more than an 8-bit divide setting. Each message object has its own stamp register. The register loads the counter value when that object reports a good receive or a good transmit. A separate sync register supports time-triggered operation. It captures the counter on the start of a frame or on the end of a frame, depending on a select input.

Counter wrap-around sets a sticky overflow flag, which software clears by writing 1. The CAN bit engine supplies the event pulses: per-object RX-OK and TX-OK, start-of-frame and end-of-frame. All of these pulses are synchronous to the block clock and last one cycle.

Top module: `can_stamp_timer`

## Requirements
- R1: While enabled, the counter increments by exactly one every 8 × (P + 1) clock cycles, where P is the active 8-bit divide value, and it wraps modulo 2^TIMER_W.
- R2: While the enable input is low, the prescaler count and the counter are held at zero, so `timer_o` reads 0 one cycle after enable is sampled low.
- R3: After enable rises, the counter reads 0 for the first 8 × (P + 1) − 1 enabled edges and reads 1 after edge 8 × (P + 1).
- R4: On the edge where the counter steps from its all-ones value to zero, `ovf_o` becomes 1.
- R5: `ovf_o` stays 1 until a cycle with `ovf_clr_i` = 1 and no wrap clears it; when a wrap and a clear fall in the same cycle, the flag is set.
- R6: A cycle with `rx_ok_i[i]` or `tx_ok_i[i]` high loads stamp i (bits i×TIMER_W upward of `stamp_o`) with the counter value. No other stamp changes.
- R7: A stamp register keeps its value in every cycle in which its own object has no OK pulse.
- R8: A capture that falls on the same edge as a counter increment records the value from before the increment.
- R9: With time-triggered mode on, `sync_o` loads the counter on `sof_i` when `sync_on_eof_i` = 0 and on `eof_i` when `sync_on_eof_i` = 1. The other strobe is ignored.
- R10: With time-triggered mode off, `sync_o` does not change.
- R11: A new divide value on `psc_i` is adopted only at the end of the running prescaler period, or while disabled. The period in progress keeps the old length.
- R12: Synchronous reset clears the counter, the overflow flag, all stamps and the sync register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| can_en_i | input | 1 | Controller enable; runs the prescaler and counter |
| psc_i | input | PSC_W | Divide value P; tick = clk / (8 × (P + 1)) |
| rx_ok_i | input | NUM_OBJ | Per-object good-receive pulse |
| tx_ok_i | input | NUM_OBJ | Per-object good-transmit pulse |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_i | input | 1 | End-of-frame strobe |
| ttc_en_i | input | 1 | Time-triggered mode enable |
| sync_on_eof_i | input | 1 | Sync edge select: 0 start of frame, 1 end of frame |
| ovf_clr_i | input | 1 | Write-1 clear of the overflow flag |
| timer_o | output | TIMER_W | Live counter value |
| stamp_o | output | NUM_OBJ × TIMER_W | Stamp registers, object i in bits i×TIMER_W upward |
| sync_o | output | TIMER_W | Time-trigger sync capture |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The counter is tested under three divide settings: 0, 3, and a switch from 0 to 3 and back in the middle of a period. Measuring the interval between counter steps separates a new value that is adopted at once from one adopted at the terminal count. Stamps are pulsed on one object at a time, using both receive and transmit pulses, and one pulse is placed on an increment edge so that pre-increment and post-increment capture give different results. The sync path is driven with each strobe under each select value and with the mode off, after it already holds a nonzero value, so that a wrong edge or an ignored mode bit is visible. Overflow is checked at a plain wrap, over a long hold, at a lone clear, and with a clear held across the wrap edge.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;
  // fixed pre-divide of the system clock ahead of the programmable stage: 2**3 = 8
  localparam int DIV_LOG2 = 3;

  typedef enum logic {
    SYNC_AT_SOF = 1'b0,
    SYNC_AT_EOF = 1'b1
  } sync_edge_e;
endpackage

// File: rtl/cst_prescaler.sv
`timescale 1ns/1ps
module cst_prescaler #(
  parameter int PSC_W    = 8,
  parameter int DIV_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int CNT_W = PSC_W + DIV_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_act_q;
  logic [CNT_W-1:0] last_w;

  // terminal count 8*(P+1)-1 equals P followed by DIV_LOG2 ones
  assign last_w = {psc_act_q, {DIV_LOG2{1'b1}}};
  assign tick_o = en_i && (cnt_q == last_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      psc_act_q <= '0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      psc_act_q <= psc_i;
    end else if (tick_o) begin
      cnt_q     <= '0;
      psc_act_q <= psc_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cst_timebase.sv
`timescale 1ns/1ps
module cst_timebase #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               clr_i,
  output logic [TIMER_W-1:0] count_o,
  output logic               ovf_o
);
  localparam logic [TIMER_W-1:0] ALL_ONES = '1;

  logic wrap_w;
  assign wrap_w = en_i && tick_i && (count_o == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      count_o <= '0;
    end else if (tick_i) begin
      count_o <= count_o + 1'b1;
    end
  end

  // set has priority over the software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o <= 1'b0;
    end else if (wrap_w) begin
      ovf_o <= 1'b1;
    end else if (clr_i) begin
      ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cst_capture.sv
`timescale 1ns/1ps
module cst_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/can_stamp_timer.sv
`timescale 1ns/1ps
module can_stamp_timer #(
  parameter int NUM_OBJ = 6,
  parameter int TIMER_W = 16,
  parameter int PSC_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       can_en_i,
  input  logic [PSC_W-1:0]           psc_i,
  input  logic [NUM_OBJ-1:0]         rx_ok_i,
  input  logic [NUM_OBJ-1:0]         tx_ok_i,
  input  logic                       sof_i,
  input  logic                       eof_i,
  input  logic                       ttc_en_i,
  input  logic                       sync_on_eof_i,
  input  logic                       ovf_clr_i,
  output logic [TIMER_W-1:0]         timer_o,
  output logic [NUM_OBJ*TIMER_W-1:0] stamp_o,
  output logic [TIMER_W-1:0]         sync_o,
  output logic                       ovf_o
);
  import cst_pkg::*;

  logic       tick_w;
  logic       sync_hit_w;
  sync_edge_e edge_sel_w;

  cst_prescaler #(.PSC_W(PSC_W), .DIV_LOG2(DIV_LOG2)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .en_i   (can_en_i),
    .psc_i  (psc_i),
    .tick_o (tick_w)
  );

  cst_timebase #(.TIMER_W(TIMER_W)) u_tbase (
    .clk     (clk),
    .rst     (rst),
    .en_i    (can_en_i),
    .tick_i  (tick_w),
    .clr_i   (ovf_clr_i),
    .count_o (timer_o),
    .ovf_o   (ovf_o)
  );

  // stamps sample the registered counter, i.e. the pre-increment value
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    cst_capture #(.W(TIMER_W)) u_stamp (
      .clk    (clk),
      .rst    (rst),
      .load_i (rx_ok_i[g] | tx_ok_i[g]),
      .d_i    (timer_o),
      .q_o    (stamp_o[g*TIMER_W +: TIMER_W])
    );
  end

  assign edge_sel_w = sync_edge_e'(sync_on_eof_i);
  assign sync_hit_w = ttc_en_i && ((edge_sel_w == SYNC_AT_EOF) ? eof_i : sof_i);

  cst_capture #(.W(TIMER_W)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .load_i (sync_hit_w),
    .d_i    (timer_o),
    .q_o    (sync_o)
  );
endmodule

// File: rtl/cst_checker.sv
`timescale 1ns/1ps
module cst_checker #(
  parameter int NUM_OBJ = 6,
  parameter int TIMER_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       can_en_i,
  input logic [NUM_OBJ-1:0]         rx_ok_i,
  input logic [NUM_OBJ-1:0]         tx_ok_i,
  input logic                       ttc_en_i,
  input logic                       ovf_clr_i,
  input logic [TIMER_W-1:0]         timer_o,
  input logic [NUM_OBJ*TIMER_W-1:0] stamp_o,
  input logic [TIMER_W-1:0]         sync_o,
  input logic                       ovf_o
);
  localparam logic [TIMER_W-1:0] TOP = '1;

  // R2
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !can_en_i |=> timer_o == '0);

  // R1
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (can_en_i && $past(can_en_i)) |->
      (timer_o == $past(timer_o) || timer_o == TIMER_W'($past(timer_o) + 1'b1)));

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (timer_o == '0 && $past(timer_o) == TOP && $past(can_en_i)) |-> ovf_o);

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R10
  sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ttc_en_i |=> $stable(sync_o));

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_chk
    // R6
    stamp_load_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_ok_i[g] || tx_ok_i[g]) |=> stamp_o[g*TIMER_W +: TIMER_W] == $past(timer_o));
    // R7
    stamp_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(rx_ok_i[g] || tx_ok_i[g]) |=> $stable(stamp_o[g*TIMER_W +: TIMER_W]));
  end
endmodule

bind can_stamp_timer cst_checker #(.NUM_OBJ(NUM_OBJ), .TIMER_W(TIMER_W)) u_cst_checker (
  .clk       (clk),
  .rst       (rst),
  .can_en_i  (can_en_i),
  .rx_ok_i   (rx_ok_i),
  .tx_ok_i   (tx_ok_i),
  .ttc_en_i  (ttc_en_i),
  .ovf_clr_i (ovf_clr_i),
  .timer_o   (timer_o),
  .stamp_o   (stamp_o),
  .sync_o    (sync_o),
  .ovf_o     (ovf_o)
);

// File: tb/can_stamp_timer_bench.sv
`timescale 1ns/1ps
module can_stamp_timer_bench;
  localparam int NOBJ = 6;
  localparam int TW   = 10;
  localparam int PW   = 8;
  localparam int MODV = 1 << TW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic can_en = 1'b0;
  logic [PW-1:0] psc = '0;
  logic [NOBJ-1:0] rx_ok = '0;
  logic [NOBJ-1:0] tx_ok = '0;
  logic sof = 1'b0, eof = 1'b0, ttc = 1'b0, sel_eof = 1'b0, ovf_clr = 1'b0;
  logic [TW-1:0] timer_o;
  logic [NOBJ*TW-1:0] stamp_o;
  logic [TW-1:0] sync_o;
  logic ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  can_stamp_timer #(.NUM_OBJ(NOBJ), .TIMER_W(TW), .PSC_W(PW)) u_can_stamp_timer (
    .clk(clk), .rst(rst), .can_en_i(can_en), .psc_i(psc), .rx_ok_i(rx_ok), .tx_ok_i(tx_ok),
    .sof_i(sof), .eof_i(eof), .ttc_en_i(ttc), .sync_on_eof_i(sel_eof), .ovf_clr_i(ovf_clr),
    .timer_o(timer_o), .stamp_o(stamp_o), .sync_o(sync_o), .ovf_o(ovf_o)
  );

  function automatic int stamp_of(int i);
    return int'(stamp_o[i*TW +: TW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int m_cnt = 0, m_pact = 0, m_tim = 0, m_ovf = 0, m_sync = 0;
  int m_stamp[NOBJ];

  always @(posedge clk) begin
    int old_t;
    bit tk;
    if (rst) begin
      m_cnt = 0; m_pact = 0; m_tim = 0; m_ovf = 0; m_sync = 0;
      for (int i = 0; i < NOBJ; i++) m_stamp[i] = 0;
    end else begin
      old_t = m_tim;
      tk = can_en && (m_cnt == 8 * (m_pact + 1) - 1);
      for (int i = 0; i < NOBJ; i++)
        if (rx_ok[i] || tx_ok[i]) m_stamp[i] = old_t;
      if (ttc && (sel_eof ? eof : sof)) m_sync = old_t;
      if (tk && old_t == MODV - 1) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (!can_en) begin
        m_cnt = 0; m_pact = int'(psc); m_tim = 0;
      end else if (tk) begin
        m_cnt = 0; m_pact = int'(psc); m_tim = (old_t + 1) % MODV;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 timer vs model", int'(timer_o), m_tim);
      chk("R4 ovf vs model", int'(ovf_o), m_ovf);
      chk("R9 sync vs model", int'(sync_o), m_sync);
      for (int i = 0; i < NOBJ; i++) chk("R6 stamp vs model", stamp_of(i), m_stamp[i]);
    end
  end

  // all stimulus lands 2 ns after a rising edge
  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wait_change(output int n);
    logic [TW-1:0] prev;
    prev = timer_o;
    n = 0;
    do begin cyc(1); n++; end while (timer_o == prev);
  endtask

  task automatic pulse_obj(int idx, bit use_tx);
    int t;
    t = int'(timer_o);
    if (use_tx) tx_ok[idx] = 1'b1; else rx_ok[idx] = 1'b1;
    cyc(1);
    tx_ok = '0; rx_ok = '0;
    #1 chk("R6 stamp load", stamp_of(idx), t);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, t, s;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    #1;
    chk("R12 timer after reset", int'(timer_o), 0);
    chk("R12 ovf after reset", int'(ovf_o), 0);
    chk("R12 sync after reset", int'(sync_o), 0);
    for (int i = 0; i < NOBJ; i++) chk("R12 stamp after reset", stamp_of(i), 0);

    cyc(20); #1 chk("R2 idle while disabled", int'(timer_o), 0);

    // start with P = 0: one step per 8 edges
    can_en = 1'b1;
    cyc(7); #1 chk("R3 zero before first tick", int'(timer_o), 0);
    cyc(1); #1 chk("R3 first tick", int'(timer_o), 1);
    cyc(40); #1 chk("R1 rate P=0", int'(timer_o), 6);
    cyc(7);
    rx_ok[1] = 1'b1;
    cyc(1);
    rx_ok = '0;
    #1 chk("R8 pre-increment stamp", stamp_of(1), 6);
    chk("R8 timer stepped", int'(timer_o), 7);

    cyc(5); pulse_obj(3, 1'b1);
    cyc(13); pulse_obj(0, 1'b0);
    t = stamp_of(3);
    cyc(40); #1 chk("R7 stamp held", stamp_of(3), t);

    // sync register
    ttc = 1'b1; sel_eof = 1'b0;
    cyc(9);
    s = int'(sync_o);
    eof = 1'b1; cyc(1); eof = 1'b0; #1 chk("R9 eof ignored sel=0", int'(sync_o), s);
    cyc(4);
    t = int'(timer_o); sof = 1'b1; cyc(1); sof = 1'b0; #1 chk("R9 sof capture", int'(sync_o), t);
    cyc(30);
    sel_eof = 1'b1;
    s = int'(sync_o);
    sof = 1'b1; cyc(1); sof = 1'b0; #1 chk("R9 sof ignored sel=1", int'(sync_o), s);
    cyc(11);
    t = int'(timer_o); eof = 1'b1; cyc(1); eof = 1'b0; #1 chk("R9 eof capture", int'(sync_o), t);
    cyc(20);
    ttc = 1'b0;
    s = int'(sync_o);
    sof = 1'b1; cyc(1); sof = 1'b0; eof = 1'b1; cyc(1); eof = 1'b0;
    sel_eof = 1'b0; sof = 1'b1; cyc(1); sof = 1'b0;
    #1 chk("R10 sync frozen", int'(sync_o), s);

    // divide change adopted at terminal count
    wait_change(n);
    cyc(2);
    psc = 8'd3;
    wait_change(n); chk("R11 old period finishes", n, 6);
    wait_change(n); chk("R11 new period P=3", n, 32);
    psc = 8'd0;
    wait_change(n); chk("R11 old P=3 period kept", n, 32);
    wait_change(n); chk("R1 back to P=0", n, 8);

    // overflow
    while (!ovf_o) cyc(1);
    #1 chk("R4 timer zero at wrap", int'(timer_o), 0);
    cyc(50); #1 chk("R5 flag sticky", int'(ovf_o), 1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    #1 chk("R5 flag cleared", int'(ovf_o), 0);
    while (timer_o != TW'(MODV - 1)) cyc(1);
    ovf_clr = 1'b1;
    do cyc(1); while (timer_o != '0);
    ovf_clr = 1'b0;
    #1 chk("R5 set beats clear", int'(ovf_o), 1);

    // disable and restart
    cyc(17);
    can_en = 1'b0;
    cyc(1); #1 chk("R2 cleared on disable", int'(timer_o), 0);
    cyc(30); #1 chk("R2 held while disabled", int'(timer_o), 0);
    can_en = 1'b1;
    cyc(7); #1 chk("R3 restart zero", int'(timer_o), 0);
    cyc(1); #1 chk("R3 restart first tick", int'(timer_o), 1);
    cyc(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule